// File: doc/BRIEF.md
# Matrix Converter Modulation Segment Sequencer

This block times one switching period of space vector modulation for a three-phase to three-phase matrix converter. It takes four active-vector on-times and a total zero-vector on-time, all in clock ticks. It also takes an output-voltage sector, an input-current sector and a choice of where the zero time goes. From these it drives nine switch enables. Each output phase A, B and C is tied to exactly one of the input phases a, b or c for every tick of the period.

The period is a fixed number of clock ticks. The default of 40000 ticks gives 5 kHz from a 200 MHz clock. Seven slots are defined. There are three zero states: all outputs on b, all on a, and all on c. There are four active states, which come from a sector table. The zero time can go in one of four places: ahead of the active states, between the second and third of them, after them, or split into three parts. In the symmetric mode each slot runs for half its time on the way out. The last slot runs whole in the centre, and the slots then repeat in reverse order. Commutation timing, duty calculation and sector detection are left to other blocks.

Top module: `mc_svm_sequencer`

## Requirements
- R1: While reset is high, and on the first clock edge after it falls, all nine switch enables and `period_start` are 0.
- R2: `period_start` is high for one cycle every PERIOD cycles. In the cycle where it is high, the enables show tick 0 of a new period.
- R3: Enable bit 3*p+i ties output phase p (A=0, B=1, C=2) to input phase i (a=0, b=1, c=2). At most one bit in each group of three is ever high.
- R4: The slot states are listed here as letters for outputs A, B and C, for input sector 1 and output sectors I to VI (`out_sector` 0 to 5). Slot 0 is bbb. Slot 3 is aaa. Slot 6 is ccc. Slot 1 is abb, bab, bab, bba, bba, abb. Slot 2 is aab, aab, baa, baa, aba, aba. Slot 4 is aac, aac, caa, caa, aca, aca. Slot 5 is acc, cac, cac, cca, cca, acc.
- R5: Slots 1, 2, 4 and 5 take the active times v1, v2, v3 and v4. `zero_place` sets where the whole zero time goes: 0 puts it in slot 0, 1 in slot 3 and 2 in slot 6. The other zero slots get length 0.
- R6: `zero_place` 3 gives slot 0 the time `duty_z_first` and slot 3 the time `duty_z_mid`. Slot 6 gets the zero time minus both, or 0 if their sum exceeds the zero time.
- R7: In one-sided mode (`bilateral` 0) the slots run in order 0 to 6. Each slot holds for its length, counted from where the slots before it end.
- R8: With `bilateral` 1, slots 0 to 5 run for floor(len/2) ticks and slot 6 runs for its full length. Then slots 5 down to 0 each run for len minus floor(len/2) ticks.
- R9: A slot of length 0 never appears on the enables, not even for one tick.
- R10: For `in_sector` k (0 to 5 for sectors 1 to 6), each input letter in the R4 table is advanced by (ROT_STEP*k) mod 3 positions, in the order a→b→c→a.
- R11: All inputs are captured only at the start of a period. A change in the middle of a period has no effect until the next period.
- R12: If the slot lengths add up to fewer ticks than the period, the enables hold the last state shown for the rest of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_v1 | input | DW | Time of slot 1, in ticks |
| duty_v2 | input | DW | Time of slot 2, in ticks |
| duty_v3 | input | DW | Time of slot 4, in ticks |
| duty_v4 | input | DW | Time of slot 5, in ticks |
| duty_zero | input | DW | Total zero-vector time, in ticks |
| duty_z_first | input | DW | Split mode: time of slot 0 |
| duty_z_mid | input | DW | Split mode: time of slot 3 |
| zero_place | input | 2 | 0 leading, 1 middle, 2 trailing, 3 split |
| bilateral | input | 1 | 1 selects the mirrored half-time order |
| out_sector | input | 3 | Output-voltage sector, 0 to 5 |
| in_sector | input | 3 | Input-current sector, 0 to 5 |
| sw_en | output | 9 | Switch enables, bit 3*p+i |
| period_start | output | 1 | High while the enables show tick 0 |

## Verification
The table and slot order are checked tick by tick against a model in the bench. The cases are each zero placement in one-sided mode, spread over different output sectors, so that each zero state and each column of the table is reached. A split case with zero mid time separates the symmetric ordering and the whole-time centre slot from a plain forward order. A run with input sector 3 shows whether the letter rotation is applied. Separate runs cover these cases. A zero-length active slot checks that such slots are skipped. An over-large split checks the clamp on the third zero part. Inputs changed in mid-period check when values are captured. Slot lengths that fall short of the period check that the final state is held.

// File: rtl/mc_svm_pkg.sv
package mc_svm_pkg;
  localparam int NSLOT = 7;
  localparam int NPOS  = 13;

  typedef logic [1:0] phase_t;            // 0 = a, 1 = b, 2 = c
  typedef phase_t [2:0] vstate_t;         // index 0 = A, 1 = B, 2 = C

  typedef enum logic [1:0] {
    ZP_LEAD  = 2'd0,
    ZP_MID   = 2'd1,
    ZP_TRAIL = 2'd2,
    ZP_SPLIT = 2'd3
  } zplace_e;

  localparam phase_t PA = 2'd0;
  localparam phase_t PB = 2'd1;
  localparam phase_t PC = 2'd2;

  function automatic vstate_t mk(input phase_t x, input phase_t y, input phase_t z);
    vstate_t v;
    v[0] = x; v[1] = y; v[2] = z;
    return v;
  endfunction

  // Slot states for input sector 1
  function automatic vstate_t base_state(input int slot, input logic [2:0] osec);
    vstate_t v;
    v = mk(PB, PB, PB);
    case (slot)
      0: v = mk(PB, PB, PB);
      3: v = mk(PA, PA, PA);
      6: v = mk(PC, PC, PC);
      1: case (osec)
           3'd1, 3'd2: v = mk(PB, PA, PB);
           3'd3, 3'd4: v = mk(PB, PB, PA);
           default:    v = mk(PA, PB, PB);
         endcase
      2: case (osec)
           3'd2, 3'd3: v = mk(PB, PA, PA);
           3'd4, 3'd5: v = mk(PA, PB, PA);
           default:    v = mk(PA, PA, PB);
         endcase
      4: case (osec)
           3'd2, 3'd3: v = mk(PC, PA, PA);
           3'd4, 3'd5: v = mk(PA, PC, PA);
           default:    v = mk(PA, PA, PC);
         endcase
      5: case (osec)
           3'd1, 3'd2: v = mk(PC, PA, PC);
           3'd3, 3'd4: v = mk(PC, PC, PA);
           default:    v = mk(PA, PC, PC);
         endcase
      default: v = mk(PB, PB, PB);
    endcase
    return v;
  endfunction

  function automatic phase_t rot_phase(input phase_t p, input logic [1:0] sh);
    logic [2:0] t;
    t = {1'b0, p} + {1'b0, sh};
    if (t >= 3'd3) t = t - 3'd3;
    return t[1:0];
  endfunction

  function automatic logic [2:0] pos_slot(input logic [3:0] pos);
    if (pos < 4'd7) return pos[2:0];
    return 3'(4'd12 - pos);
  endfunction
endpackage

// File: rtl/mc_period_timer.sv
module mc_period_timer #(
  parameter int PERIOD = 40000,
  parameter int CW     = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= LAST;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/mc_state_lookup.sv
module mc_state_lookup
  import mc_svm_pkg::*;
#(
  parameter int ROT_STEP = 1
) (
  input  logic [2:0]                out_sector,
  input  logic [2:0]                in_sector,
  output vstate_t [NSLOT-1:0]       slot_state
);
  logic [1:0] shift;

  always_comb shift = 2'((ROT_STEP * int'(in_sector)) % 3);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    vstate_t base;
    always_comb begin
      base = base_state(g, out_sector);
      for (int p = 0; p < 3; p++) slot_state[g][p] = rot_phase(base[p], shift);
    end
  end
endmodule

// File: rtl/mc_segment_planner.sv
module mc_segment_planner
  import mc_svm_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = DW + 3
) (
  input  logic [DW-1:0]              v1,
  input  logic [DW-1:0]              v2,
  input  logic [DW-1:0]              v3,
  input  logic [DW-1:0]              v4,
  input  logic [DW-1:0]              z_total,
  input  logic [DW-1:0]              z_first,
  input  logic [DW-1:0]              z_mid,
  input  logic [1:0]                 place,
  input  logic                       mirror,
  output logic [NPOS-1:0][SW-1:0]    cum
);
  logic [DW+1:0]            z_used;
  logic [DW-1:0]            z_last;
  logic [NSLOT-1:0][DW-1:0] dur;
  logic [NPOS-1:0][DW-1:0]  plen;

  always_comb begin
    z_used = {2'b00, z_first} + {2'b00, z_mid};
    z_last = (z_used > {2'b00, z_total}) ? '0 : DW'(z_total - z_first - z_mid);
    dur[1] = v1;
    dur[2] = v2;
    dur[4] = v3;
    dur[5] = v4;
    dur[0] = (place == ZP_LEAD)  ? z_total : (place == ZP_SPLIT) ? z_first : '0;
    dur[3] = (place == ZP_MID)   ? z_total : (place == ZP_SPLIT) ? z_mid   : '0;
    dur[6] = (place == ZP_TRAIL) ? z_total : (place == ZP_SPLIT) ? z_last  : '0;
  end

  for (genvar k = 0; k < NPOS; k++) begin : g_pos
    if (k < NSLOT - 1) begin : g_out
      assign plen[k] = mirror ? (dur[k] >> 1) : dur[k];
    end else if (k == NSLOT - 1) begin : g_mid
      assign plen[k] = dur[k];
    end else begin : g_back
      assign plen[k] = mirror ? DW'(dur[NPOS-1-k] - (dur[NPOS-1-k] >> 1)) : '0;
    end
  end

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int k = 0; k < NPOS; k++) begin
      acc    = acc + SW'(plen[k]);
      cum[k] = acc;
    end
  end
endmodule

// File: rtl/mc_svm_sequencer.sv
module mc_svm_sequencer
  import mc_svm_pkg::*;
#(
  parameter int PERIOD   = 40000,
  parameter int DW       = $clog2(PERIOD + 1),
  parameter int ROT_STEP = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] duty_v1,
  input  logic [DW-1:0] duty_v2,
  input  logic [DW-1:0] duty_v3,
  input  logic [DW-1:0] duty_v4,
  input  logic [DW-1:0] duty_zero,
  input  logic [DW-1:0] duty_z_first,
  input  logic [DW-1:0] duty_z_mid,
  input  logic [1:0]    zero_place,
  input  logic          bilateral,
  input  logic [2:0]    out_sector,
  input  logic [2:0]    in_sector,
  output logic [8:0]    sw_en,
  output logic          period_start
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam int SW = DW + 3;

  logic [CW-1:0] cnt;
  logic          wrap;

  logic [DW-1:0] c_v1, c_v2, c_v3, c_v4, c_z, c_zf, c_zm;
  logic [1:0]    c_place;
  logic          c_mirror;
  logic [2:0]    c_osec, c_isec;

  logic [NPOS-1:0][SW-1:0] cum;
  vstate_t [NSLOT-1:0]     slot_state;

  logic          hit;
  logic [3:0]    sel;
  vstate_t       st_now;
  logic [8:0]    mask;
  logic [8:0]    sw_q;
  logic          ps_q;

  mc_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap)
  );

  // Inputs captured only at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      {c_v1, c_v2, c_v3, c_v4, c_z, c_zf, c_zm} <= '0;
      c_place  <= '0;
      c_mirror <= 1'b0;
      c_osec   <= '0;
      c_isec   <= '0;
    end else if (wrap) begin
      c_v1 <= duty_v1; c_v2 <= duty_v2; c_v3 <= duty_v3; c_v4 <= duty_v4;
      c_z  <= duty_zero; c_zf <= duty_z_first; c_zm <= duty_z_mid;
      c_place  <= zero_place;
      c_mirror <= bilateral;
      c_osec   <= out_sector;
      c_isec   <= in_sector;
    end
  end

  mc_segment_planner #(.DW(DW), .SW(SW)) u_plan (
    .v1(c_v1), .v2(c_v2), .v3(c_v3), .v4(c_v4),
    .z_total(c_z), .z_first(c_zf), .z_mid(c_zm),
    .place(c_place), .mirror(c_mirror), .cum(cum)
  );

  mc_state_lookup #(.ROT_STEP(ROT_STEP)) u_lut (
    .out_sector(c_osec), .in_sector(c_isec), .slot_state(slot_state)
  );

  // First position whose end lies past the current tick
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = NPOS - 1; k >= 0; k--) begin
      if (cum[k] > SW'(cnt)) begin
        hit = 1'b1;
        sel = 4'(k);
      end
    end
    st_now = slot_state[pos_slot(sel)];
    mask = '0;
    for (int p = 0; p < 3; p++) begin
      case (st_now[p])
        PA:      mask[3*p]     = 1'b1;
        PB:      mask[3*p + 1] = 1'b1;
        default: mask[3*p + 2] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= '0;
      ps_q <= 1'b0;
    end else begin
      if (hit) sw_q <= mask;
      ps_q <= (cnt == '0);
    end
  end

  assign sw_en        = sw_q;
  assign period_start = ps_q;

  assert_group_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw_q[2:0]) && $onehot0(sw_q[5:3]) && $onehot0(sw_q[8:6]));
  assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
    ps_q |=> !ps_q);
  assert_capture_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(c_v1) && $stable(c_z) && $stable(c_place) &&
              $stable(c_mirror) && $stable(c_osec) && $stable(c_isec));
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(sw_q));
endmodule

// File: tb/tb_mc_svm_sequencer.sv
module tb_mc_svm_sequencer;
  localparam int P  = 40;
  localparam int DW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] v1, v2, v3, v4, z0, zf, zm;
  logic [1:0] place;
  logic bil;
  logic [2:0] osec, isec;
  logic [8:0] sw_en;
  logic period_start;

  int n_tests = 0;
  int n_fail  = 0;

  int         mlen [13];
  logic [8:0] mst  [13];

  always #2.5 clk = ~clk;

  mc_svm_sequencer #(.PERIOD(P)) dut (
    .clk(clk), .rst(rst),
    .duty_v1(v1), .duty_v2(v2), .duty_v3(v3), .duty_v4(v4),
    .duty_zero(z0), .duty_z_first(zf), .duty_z_mid(zm),
    .zero_place(place), .bilateral(bil),
    .out_sector(osec), .in_sector(isec),
    .sw_en(sw_en), .period_start(period_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tbl(input int slot, input int o);
    case (slot)
      0: return "bbb";
      3: return "aaa";
      6: return "ccc";
      1: case (o) 0,5: return "abb"; 1,2: return "bab"; default: return "bba"; endcase
      2: case (o) 0,1: return "aab"; 2,3: return "baa"; default: return "aba"; endcase
      4: case (o) 0,1: return "aac"; 2,3: return "caa"; default: return "aca"; endcase
      default: case (o) 0,5: return "acc"; 1,2: return "cac"; default: return "cca"; endcase
    endcase
  endfunction

  function automatic logic [8:0] smask(input int slot);
    string s;
    logic [8:0] m;
    s = tbl(slot, int'(osec));
    m = '0;
    for (int p = 0; p < 3; p++) begin
      int idx;
      idx = (int'(s[p]) - int'("a") + int'(isec)) % 3;
      m[3*p + idx] = 1'b1;
    end
    return m;
  endfunction

  task automatic build_model();
    int d [7];
    int zl;
    zl = (int'(zf) + int'(zm) > int'(z0)) ? 0 : int'(z0) - int'(zf) - int'(zm);
    d[1] = v1; d[2] = v2; d[4] = v3; d[5] = v4;
    d[0] = (place == 0) ? int'(z0) : (place == 3) ? int'(zf) : 0;
    d[3] = (place == 1) ? int'(z0) : (place == 3) ? int'(zm) : 0;
    d[6] = (place == 2) ? int'(z0) : (place == 3) ? zl : 0;
    for (int k = 0; k < 13; k++) begin
      int s;
      s = (k < 7) ? k : 12 - k;
      mst[k] = smask(s);
      if (!bil) mlen[k] = (k < 7) ? d[k] : 0;
      else if (k < 6) mlen[k] = d[k] / 2;
      else if (k == 6) mlen[k] = d[6];
      else mlen[k] = d[s] - d[s] / 2;
    end
  endtask

  function automatic logic [8:0] exp_at(input int t, input logic [8:0] hold);
    int acc;
    acc = 0;
    for (int k = 0; k < 13; k++) begin
      acc += mlen[k];
      if (t < acc) return mst[k];
    end
    return hold;
  endfunction

  task automatic set_in(input int a1, a2, a3, a4, az, azf, azm, input int pl, b, o, i);
    v1 = DW'(a1); v2 = DW'(a2); v3 = DW'(a3); v4 = DW'(a4);
    z0 = DW'(az); zf = DW'(azf); zm = DW'(azm);
    place = 2'(pl); bil = 1'(b); osec = 3'(o); isec = 3'(i);
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!period_start) @(negedge clk);
  endtask

  // Checks the period whose tick 0 is at the current negedge
  task automatic check_period(input string req);
    logic [8:0] hold, e;
    hold = '0;
    for (int t = 0; t < P; t++) begin
      if (t > 0) @(negedge clk);
      e = exp_at(t, hold);
      hold = e;
      chk(sw_en == e, req, sw_en, e);
    end
  endtask

  task automatic run_case(input string req);
    wait_start();   // first start may carry old inputs
    wait_start();
    build_model();
    check_period(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sw_en == 9'h0 && !period_start, "R1", {period_start, sw_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sw_en == 9'h0 && !period_start, "R1", {period_start, sw_en}, 0);
  endtask

  task automatic t_period();
    int gap;
    wait_start();
    gap = 0;
    @(negedge clk);
    gap++;
    while (!period_start) begin
      @(negedge clk);
      gap++;
    end
    chk(gap == P, "R2", gap, P);
  endtask

  task automatic t_capture();
    logic [8:0] hold, e;
    set_in(6, 5, 7, 4, 18, 0, 0, 1, 0, 2, 0);
    wait_start();
    wait_start();
    build_model();
    hold = '0;
    for (int t = 0; t < P; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 10) set_in(3, 9, 2, 8, 18, 0, 0, 2, 0, 4, 0);
      if (t == 10) begin
        e = exp_at(t, hold);
      end else begin
        e = exp_at(t, hold);
      end
      hold = e;
      chk(sw_en == e, "R11", sw_en, e);
    end
    wait_start();
    build_model();
    check_period("R11");
  endtask

  initial begin
    set_in(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    t_reset();
    // R4 R5 R7: leading zero, sector I
    set_in(6, 5, 7, 4, 18, 0, 0, 0, 0, 0, 0);
    run_case("R5");
    // R4 R5: middle zero, sector III
    set_in(6, 5, 7, 4, 18, 0, 0, 1, 0, 2, 0);
    run_case("R4");
    // R5 R7: trailing zero, sector VI
    set_in(6, 5, 7, 4, 18, 0, 0, 2, 0, 5, 0);
    run_case("R7");
    // R6: split zero, sector II
    set_in(6, 5, 7, 4, 18, 5, 6, 3, 0, 1, 0);
    run_case("R6");
    // R6: split parts exceed total, last part clamps to 0
    set_in(6, 5, 7, 4, 18, 10, 10, 3, 0, 3, 0);
    run_case("R6");
    // R8: mirrored split, sector IV
    set_in(6, 5, 7, 4, 18, 5, 6, 3, 1, 3, 0);
    run_case("R8");
    // R8: mirrored, trailing zero, odd times, sector V
    set_in(7, 5, 9, 3, 16, 0, 0, 2, 1, 4, 0);
    run_case("R8");
    // R9: zero-length active slots
    set_in(9, 0, 13, 0, 18, 0, 0, 1, 1, 1, 0);
    run_case("R9");
    // R10: input sector 3 rotates letters by two
    set_in(6, 5, 7, 4, 18, 5, 6, 3, 0, 0, 2);
    run_case("R10");
    // R10: input sector 2
    set_in(6, 5, 7, 4, 18, 0, 0, 1, 1, 4, 1);
    run_case("R10");
    // R12: lengths short of the period
    set_in(4, 3, 5, 2, 6, 0, 0, 0, 0, 1, 0);
    run_case("R12");
    // R3: enables stay one-hot per group across a full period
    set_in(6, 5, 7, 4, 18, 5, 6, 3, 1, 5, 4);
    run_case("R3");
    t_capture();
    t_period();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule